// File: doc/BRIEF.md
# Two-Level ALU Operation Decoder and 32-bit ALU

This block turns a coarse instruction-class code and a function field into a concrete ALU operation, then applies that operation to two operands. A main controller supplies a 2-bit class. The class either forces an operation or hands the choice to the 6-bit function field of a register-format instruction. The resulting 4-bit operation code drives a combinational ALU. The ALU returns a result word and a flag that is high when the result is zero.

The ALU never receives an opcode directly. Load/store address generation always adds. Branch-on-equal always subtracts, and the zero flag then gives the branch decision. Register arithmetic and logic follow the function field. The block has no clock and no state, so outputs follow inputs within the same cycle.

Top module: `alu_unit`

## Requirements
- R1: The 4-bit operation code on `op_o` is 0000 for AND, 0001 for OR, 0010 for add, 0110 for subtract, 0111 for set-on-less-than and 1100 for NOR.
- R2: Class 00 (memory access) selects add whatever the function field holds.
- R3: Class 01 (branch-if-equal) selects subtract whatever the function field holds.
- R4: Class 10 decodes the function field: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 set-on-less-than, 100111 NOR.
- R5: Class 11, and class 10 with any other function value, select add.
- R6: Add and subtract produce the sum A+B and the difference A-B modulo 2^32, with no overflow indication.
- R7: Set-on-less-than compares A and B as signed two's-complement numbers and gives 1 when A < B, otherwise 0.
- R8: AND, OR and NOR give A&B, A|B and ~(A|B) bit by bit.
- R9: `zero_o` is 1 exactly when all 32 result bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cls_i | input | 2 | Instruction-class code from the main controller |
| funct_i | input | 6 | Function field of a register-format instruction |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_o | output | 4 | Decoded ALU operation code |
| result_o | output | 32 | ALU result |
| zero_o | output | 1 | High when the result is all zeros |

## Verification
The decoder is tried with every class code against several function values: the six legal ones, near misses that differ from a legal code in one bit, and all-zero and all-one fields. This shows that forcing classes ignore the field and that unknown codes fall back to add. The datapath is driven with carry and borrow wrap operands and with sign-mixed pairs for the comparison, where a signed and an unsigned compare give different answers. Equal and unequal branch operands separate a correct zero flag from a stuck or inverted one. Complementary bit patterns tell the three logic operations apart.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_MEM    = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_REG    = 2'b10,
        CLS_RSVD   = 2'b11
    } alu_cls_e;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_NOR = 6'b100111;
    localparam logic [5:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
#(
    parameter int FN_W = 6
) (
    input  logic [1:0]      cls_i,
    input  logic [FN_W-1:0] funct_i,
    output alu_op_e         op_o
);
    alu_op_e fn_op_d;
    alu_op_e op_d;

    always_comb begin
        case (funct_i)
            FN_ADD:  fn_op_d = ALU_ADD;
            FN_SUB:  fn_op_d = ALU_SUB;
            FN_AND:  fn_op_d = ALU_AND;
            FN_OR:   fn_op_d = ALU_OR;
            FN_NOR:  fn_op_d = ALU_NOR;
            FN_SLT:  fn_op_d = ALU_SLT;
            default: fn_op_d = ALU_ADD;
        endcase
    end

    always_comb begin
        case (alu_cls_e'(cls_i))
            CLS_MEM:    op_d = ALU_ADD;
            CLS_BRANCH: op_d = ALU_SUB;
            CLS_REG:    op_d = fn_op_d;
            default:    op_d = ALU_ADD;
        endcase
    end

    assign op_o = op_d;

    always_comb begin
        if (cls_i == 2'b00) assert_mem_add_R2: assert (op_o == ALU_ADD);
        if (cls_i == 2'b01) assert_branch_sub_R3: assert (op_o == ALU_SUB);
        if (cls_i == 2'b11) assert_rsvd_add_R5: assert (op_o == ALU_ADD);
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);
    logic [WIDTH-1:0] sum_d;
    logic [WIDTH-1:0] diff_d;
    logic             lt_d;
    logic [WIDTH-1:0] res_d;

    assign sum_d  = a_i + b_i;
    assign diff_d = a_i - b_i;
    assign lt_d   = $signed(a_i) < $signed(b_i);

    always_comb begin
        case (op_i)
            ALU_AND: res_d = a_i & b_i;
            ALU_OR:  res_d = a_i | b_i;
            ALU_ADD: res_d = sum_d;
            ALU_SUB: res_d = diff_d;
            ALU_SLT: res_d = {{(WIDTH-1){1'b0}}, lt_d};
            ALU_NOR: res_d = ~(a_i | b_i);
            default: res_d = sum_d;
        endcase
    end

    assign res_o = res_d;

    always_comb begin
        if (op_i == ALU_SLT) assert_slt_bool_R7: assert (res_o[WIDTH-1:1] == '0);
        if (op_i == ALU_AND) assert_and_subset_R8: assert ((res_o & ~b_i) == '0);
        if (op_i == ALU_OR)  assert_or_cover_R8: assert ((res_o & a_i) == a_i);
        if (op_i == ALU_NOR) assert_nor_disjoint_R8: assert ((res_o & b_i) == '0);
        if (op_i == ALU_SUB) assert_sub_inverse_R6: assert (res_o + b_i == a_i);
    end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] val_i,
    output logic             zero_o
);
    assign zero_o = ~(|val_i);
endmodule

// File: rtl/alu_unit.sv
module alu_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int FN_W  = 6
) (
    input  logic [1:0]       cls_i,
    input  logic [FN_W-1:0]  funct_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [3:0]       op_o,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o
);
    alu_op_e op_d;

    alu_op_decode #(.FN_W(FN_W)) u_dec (
        .cls_i   (cls_i),
        .funct_i (funct_i),
        .op_o    (op_d)
    );

    alu_core #(.WIDTH(WIDTH)) u_core (
        .op_i  (op_d),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (result_o)
    );

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .val_i  (result_o),
        .zero_o (zero_o)
    );

    assign op_o = op_d;

    always_comb begin
        if (cls_i == 2'b01) assert_branch_eq_R9: assert (zero_o == (a_i == b_i));
        if (zero_o) assert_zero_empty_R9: assert (result_o == '0);
    end
endmodule

// File: tb/sim_alu_unit.sv
module sim_alu_unit;
    logic        clk = 1'b0;
    logic [1:0]  cls;
    logic [5:0]  funct;
    logic [31:0] a, b;
    logic [3:0]  op;
    logic [31:0] res;
    logic        zero;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    alu_unit u0 (
        .cls_i(cls), .funct_i(funct), .a_i(a), .b_i(b),
        .op_o(op), .result_o(res), .zero_o(zero)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(logic [1:0] c, logic [5:0] f, logic [31:0] x, logic [31:0] y);
        @(negedge clk);
        cls = c; funct = f; a = x; b = y;
        #1;
    endtask

    // R4 / R1: each legal function field and its code
    task automatic t_funct_map();
        logic [5:0] fn [6] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010, 6'b100111};
        logic [3:0] oc [6] = '{4'b0010, 4'b0110, 4'b0000, 4'b0001, 4'b0111, 4'b1100};
        for (int i = 0; i < 6; i++) begin
            apply(2'b10, fn[i], 32'h0, 32'h0);
            chk("R4/R1 op code", {28'h0, op}, {28'h0, oc[i]});
        end
    endtask

    // R2 R3 R5: forcing classes and fallbacks
    task automatic t_forced();
        logic [5:0] fv [5] = '{6'b000000, 6'b111111, 6'b100100, 6'b101010, 6'b100110};
        for (int i = 0; i < 5; i++) begin
            apply(2'b00, fv[i], 32'd7, 32'd5);
            chk("R2 mem op", {28'h0, op}, 32'h2);
            chk("R2 mem result", res, 32'd12);
            apply(2'b01, fv[i], 32'd7, 32'd5);
            chk("R3 branch op", {28'h0, op}, 32'h6);
            chk("R3 branch result", res, 32'd2);
            apply(2'b11, fv[i], 32'd7, 32'd5);
            chk("R5 class11 op", {28'h0, op}, 32'h2);
        end
        apply(2'b10, 6'b100110, 32'd3, 32'd4);
        chk("R5 unknown funct op", {28'h0, op}, 32'h2);
        chk("R5 unknown funct result", res, 32'd7);
        apply(2'b10, 6'b000000, 32'd3, 32'd4);
        chk("R5 zero funct op", {28'h0, op}, 32'h2);
    endtask

    // R6 wrap
    task automatic t_arith();
        apply(2'b10, 6'b100000, 32'hFFFF_FFFF, 32'd1);
        chk("R6 add wrap", res, 32'h0);
        chk("R9 zero after wrap", {31'h0, zero}, 32'd1);
        apply(2'b10, 6'b100000, 32'h1234_5678, 32'h1111_1111);
        chk("R6 add", res, 32'h2345_6789);
        apply(2'b10, 6'b100010, 32'd0, 32'd1);
        chk("R6 sub borrow", res, 32'hFFFF_FFFF);
        chk("R9 nonzero", {31'h0, zero}, 32'd0);
    endtask

    // R7 signed compare
    task automatic t_slt();
        apply(2'b10, 6'b101010, 32'hFFFF_FFFF, 32'd1);
        chk("R7 -1<1", res, 32'd1);
        apply(2'b10, 6'b101010, 32'd1, 32'hFFFF_FFFF);
        chk("R7 1<-1", res, 32'd0);
        apply(2'b10, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF);
        chk("R7 min<max", res, 32'd1);
        apply(2'b10, 6'b101010, 32'd5, 32'd5);
        chk("R7 equal", res, 32'd0);
        chk("R9 slt false zero", {31'h0, zero}, 32'd1);
    endtask

    // R8 logic
    task automatic t_logic();
        apply(2'b10, 6'b100100, 32'hF0F0_AAAA, 32'hFF00_5555);
        chk("R8 and", res, 32'hF000_0000);
        apply(2'b10, 6'b100101, 32'hF0F0_AAAA, 32'hFF00_5555);
        chk("R8 or", res, 32'hFFF0_FFFF);
        apply(2'b10, 6'b100111, 32'hF0F0_AAAA, 32'hFF00_5555);
        chk("R8 nor", res, 32'h000F_0000);
        apply(2'b10, 6'b100111, 32'hFFFF_0000, 32'h0000_FFFF);
        chk("R9 nor all zero", {31'h0, zero}, 32'd1);
    endtask

    // R9 branch equality
    task automatic t_branch_zero();
        apply(2'b01, 6'b101010, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        chk("R9 equal", {31'h0, zero}, 32'd1);
        apply(2'b01, 6'b101010, 32'hDEAD_BEEF, 32'hDEAD_BEEE);
        chk("R9 unequal", {31'h0, zero}, 32'd0);
    endtask

    initial begin
        cls = 2'b00; funct = 6'h0; a = 32'h0; b = 32'h0;
        #1;
        chk("R2 initial op", {28'h0, op}, 32'h2);
        chk("R9 initial zero", {31'h0, zero}, 32'd1);
        t_funct_map();
        t_forced();
        t_arith();
        t_slt();
        t_logic();
        t_branch_zero();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 10000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule